// File: doc/BRIEF.md
# Sync Edge Phase Aligner

This block takes a free-running external periodic sync signal and uses its rising edges to pull an internal clock-generator counter into a known phase. The incoming level is first brought into the system-clock domain by a two-stage synchronizer. It then passes through a programmable delay of zero to seven system-clock cycles and goes to an edge detector. For every rising edge found, the detector emits a pulse one system clock wide, so the pulse rate follows the sync frequency.

The clock-generator counter counts modulo `MOD_N`. When a pulse arrives and the preset enable is high, the counter is forced to its preset value 0 for one cycle. It then continues its normal sequence. Several devices that share an edge-aligned sync signal therefore end up in the same counter phase. The upper counter bits are brought out as divided clocks. The pulse output is always produced, whatever the preset enable is set to.

Top module: `sync_phase_aligner`

## Requirements
- R1: Let E be the first clock edge that samples `sync_raw_i` high after it was sampled low, and let D be the value of `dly_sel_i`. `sync_pulse_o` is high for the cycle that follows clock edge E+2+D. A falling edge or a steady level of `sync_raw_i` produces no pulse.
- R2: Every pulse on `sync_pulse_o` lasts exactly one clock cycle, however long `sync_raw_i` stays high.
- R3: Each separate rising edge produces its own pulse. This holds down to an input that is high for one cycle and low for one cycle, so a periodic input gives pulses at the same period.
- R4: The 3-bit `dly_sel_i` value D, read as an unsigned number from 0 to 7, adds exactly D cycles to the pulse latency.
- R5: A pulse that arrives while `preset_en_i` is high makes `phase_cnt_o` read 0 in the cycle after the pulse.
- R6: Apart from a preset, `phase_cnt_o` advances by one every cycle through 0 to MOD_N-1 and wraps from MOD_N-1 to 0. After a preset it continues from 0 to 1.
- R7: A pulse that arrives while `preset_en_i` is low is still output, and it leaves the counter sequence unchanged.
- R8: `div_clk_o[i]` equals bit CNT_W-NUM_DIV+i of `phase_cnt_o`, where CNT_W = clog2(MOD_N). With the default MOD_N=12, bits 2 and 3 are used.
- R9: While `rst_n` is low, `sync_pulse_o` is 0, `phase_cnt_o` is 0, and all synchronizer and delay stages are cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_raw_i | input | 1 | External periodic sync level (asynchronous) |
| dly_sel_i | input | DLY_W | Added delay in clock cycles |
| preset_en_i | input | 1 | Allows pulses to preset the counter |
| sync_pulse_o | output | 1 | One-cycle pulse for each detected rising edge |
| phase_cnt_o | output | CNT_W | Clock-generator counter state |
| div_clk_o | output | NUM_DIV | Divided clocks taken from the upper counter bits |

## Verification
The hardest situations to reach from the ports are a preset that lands exactly when the counter is about to wrap, and rising edges packed so closely that several of them are in flight inside the delay line at once. The bench covers both. It sweeps every delay value with the preset enable both on and off, so presets fall at many different counter phases. It also drives square waves with periods down to two cycles through non-zero delays. A bench-side history of the driven input predicts every pulse and every counter value cycle by cycle.

// File: rtl/sync_phase_pkg.sv
package sync_phase_pkg;
  localparam int DEF_DLY_W   = 3;
  localparam int DEF_MOD_N   = 12;
  localparam int DEF_NUM_DIV = 2;
  localparam int DEF_PRESET  = 0;
endpackage

// File: rtl/sync_input_sync.sv
module sync_input_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic sync_o
);
  logic stage1_q, stage2_q;
  logic stage1_d, stage2_d;

  always_comb begin
    stage1_d = async_i;
    stage2_d = stage1_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= stage1_d;
      stage2_q <= stage2_d;
    end
  end

  assign sync_o = stage2_q;
endmodule

// File: rtl/sync_delay_line.sv
module sync_delay_line #(
  parameter int DLY_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             din_i,
  input  logic [DLY_W-1:0] sel_i,
  output logic             tap_o
);
  localparam int MAX_D = (1 << DLY_W) - 1;

  logic taps [0:MAX_D];

  assign taps[0] = din_i;

  for (genvar k = 1; k <= MAX_D; k++) begin : g_stage
    logic stage_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q <= 1'b0;
      else        stage_q <= taps[k-1];
    end
    assign taps[k] = stage_q;
  end

  assign tap_o = taps[sel_i];
endmodule

// File: rtl/sync_edge_detect.sv
module sync_edge_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic level_i,
  output logic pulse_o
);
  logic prev_q, pulse_q;
  logic prev_d, pulse_d;

  always_comb begin
    prev_d  = level_i;
    pulse_d = level_i & ~prev_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      prev_q  <= prev_d;
      pulse_q <= pulse_d;
    end
  end

  assign pulse_o = pulse_q;
endmodule

// File: rtl/phase_counter.sv
module phase_counter #(
  parameter int MOD_N  = 12,
  parameter int PRESET = 0,
  localparam int CNT_W = $clog2(MOD_N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(MOD_N - 1);
  localparam logic [CNT_W-1:0] PVAL = CNT_W'(PRESET);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    if (load_i)             cnt_d = PVAL;
    else if (cnt_q == LAST) cnt_d = '0;
    else                    cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/sync_phase_aligner.sv
module sync_phase_aligner
  import sync_phase_pkg::*;
#(
  parameter int DLY_W   = DEF_DLY_W,
  parameter int MOD_N   = DEF_MOD_N,
  parameter int NUM_DIV = DEF_NUM_DIV,
  parameter int PRESET  = DEF_PRESET,
  localparam int CNT_W  = $clog2(MOD_N)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sync_raw_i,
  input  logic [DLY_W-1:0]   dly_sel_i,
  input  logic               preset_en_i,
  output logic               sync_pulse_o,
  output logic [CNT_W-1:0]   phase_cnt_o,
  output logic [NUM_DIV-1:0] div_clk_o
);
  logic sync_lvl;
  logic dly_tap;
  logic pulse;
  logic load;
  logic [CNT_W-1:0] cnt;

  sync_input_sync u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (sync_raw_i),
    .sync_o  (sync_lvl)
  );

  sync_delay_line #(.DLY_W(DLY_W)) u_dly (
    .clk   (clk),
    .rst_n (rst_n),
    .din_i (sync_lvl),
    .sel_i (dly_sel_i),
    .tap_o (dly_tap)
  );

  sync_edge_detect u_edge (
    .clk     (clk),
    .rst_n   (rst_n),
    .level_i (dly_tap),
    .pulse_o (pulse)
  );

  assign load = pulse & preset_en_i;

  phase_counter #(.MOD_N(MOD_N), .PRESET(PRESET)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (load),
    .cnt_o  (cnt)
  );

  for (genvar i = 0; i < NUM_DIV; i++) begin : g_div
    assign div_clk_o[i] = cnt[CNT_W-NUM_DIV+i];
  end

  assign sync_pulse_o = pulse;
  assign phase_cnt_o  = cnt;
endmodule

// File: rtl/sync_phase_aligner_chk.sv
module sync_phase_aligner_chk #(
  parameter int MOD_N = 12,
  localparam int CNT_W = $clog2(MOD_N)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tap,
  input logic             pulse,
  input logic             en,
  input logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(MOD_N - 1);
  logic [CNT_W-1:0] succ;
  assign succ = (cnt == LAST) ? '0 : cnt + 1'b1;

  a_r1_rise_gives_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tap) |=> pulse);
  a_r1_no_rise_no_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(tap) |=> !pulse);
  a_r2_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |=> !pulse);
  a_r5_preset_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse && en) |=> cnt == '0);
  a_r6_advance: assert property (@(posedge clk) disable iff (!rst_n)
    !(pulse && en) |=> cnt == $past(succ));
  a_r6_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST);
endmodule

bind sync_phase_aligner sync_phase_aligner_chk #(.MOD_N(MOD_N)) u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .tap   (dly_tap),
  .pulse (sync_pulse_o),
  .en    (preset_en_i),
  .cnt   (phase_cnt_o)
);

// File: tb/sync_phase_aligner_test.sv
module sync_phase_aligner_test;
  localparam int DW = 3;
  localparam int N  = 12;
  localparam int ND = 2;
  localparam int CW = $clog2(N);

  logic clk = 1'b0;
  logic rst_n;
  logic sync_raw;
  logic en;
  logic [DW-1:0] dly;
  logic pulse;
  logic [CW-1:0] cnt;
  logic [ND-1:0] divc;

  always #5 clk = ~clk;

  sync_phase_aligner uut (
    .clk          (clk),
    .rst_n        (rst_n),
    .sync_raw_i   (sync_raw),
    .dly_sel_i    (dly),
    .preset_en_i  (en),
    .sync_pulse_o (pulse),
    .phase_cnt_o  (cnt),
    .div_clk_o    (divc)
  );

  int checks = 0;
  int errors = 0;
  int t;
  logic hist [0:63];
  logic exp_pulse;
  int exp_cnt;
  int pulses_seen;
  int first_pulse;
  bit done = 0;

  function automatic logic hv(int k);
    return (k < 0) ? 1'b0 : hist[k % 64];
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (t=%0d)", tag, act, expv, t);
    end
  endtask

  // one cycle: drive input, advance one edge, check pulse (R1), counter (R5/R6/R7), divided clocks (R8)
  task automatic step(input logic v, input logic e);
    logic prevp;
    sync_raw = v;
    en = e;
    hist[t % 64] = v;
    prevp = exp_pulse;
    @(posedge clk); #1;
    t++;
    exp_pulse = hv(t - 3 - int'(dly)) & ~hv(t - 4 - int'(dly));
    exp_cnt = (prevp && e) ? 0 : (exp_cnt + 1) % N;
    chk(pulse == exp_pulse, "R1", int'(pulse), int'(exp_pulse));
    if (prevp && e)  chk(int'(cnt) == exp_cnt, "R5", int'(cnt), exp_cnt);
    else if (prevp)  chk(int'(cnt) == exp_cnt, "R7", int'(cnt), exp_cnt);
    else             chk(int'(cnt) == exp_cnt, "R6", int'(cnt), exp_cnt);
    chk(int'(divc) == (exp_cnt >> (CW - ND)), "R8", int'(divc), exp_cnt >> (CW - ND));
    if (pulse) begin
      pulses_seen++;
      if (first_pulse < 0) first_pulse = t;
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    int rise_t;
    for (int i = 0; i < 64; i++) hist[i] = 1'b0;
    rst_n = 1'b0; sync_raw = 1'b0; en = 1'b0; dly = '0;
    t = 0; exp_cnt = 0; exp_pulse = 1'b0;
    pulses_seen = 0; first_pulse = -1;
    repeat (3) @(posedge clk);
    sync_raw = 1'b1;
    @(posedge clk); #1;
    // R9: outputs held at reset values, even with the input high
    chk(pulse == 1'b0, "R9", int'(pulse), 0);
    chk(cnt == '0, "R9", int'(cnt), 0);
    sync_raw = 1'b0;
    @(posedge clk); #1;
    rst_n = 1'b1;
    chk(cnt == '0 && pulse == 1'b0, "R9", int'(cnt), 0);

    // R2 R4 R7: single rise, every delay, preset enable off and on
    for (int d = 0; d < 8; d++) begin
      for (int e = 0; e < 2; e++) begin
        dly = DW'(d);
        pulses_seen = 0; first_pulse = -1;
        rise_t = t;
        repeat (10) step(1'b1, e[0]);
        repeat (14) step(1'b0, e[0]);
        chk(pulses_seen == 1, "R2", pulses_seen, 1);
        chk(first_pulse == rise_t + 3 + d, "R4", first_pulse, rise_t + 3 + d);
      end
    end

    // R3: square waves down to period two, through various delays
    for (int p = 1; p <= 3; p++) begin
      dly = DW'((p * 3) % 8);
      pulses_seen = 0; first_pulse = -1;
      for (int k = 0; k < 5; k++) begin
        repeat (p) step(1'b1, 1'b1);
        repeat (p) step(1'b0, 1'b1);
      end
      repeat (14) step(1'b0, 1'b1);
      chk(pulses_seen == 5, "R3", pulses_seen, 5);
    end

    // R7: toggling enable during a periodic input
    dly = 3'd1;
    for (int k = 0; k < 6; k++) begin
      repeat (2) step(1'b1, k[0]);
      repeat (3) step(1'b0, k[0]);
    end
    repeat (14) step(1'b0, 1'b0);

    done = 1;
    summary();
    $finish;
  end
endmodule